// File: doc/BRIEF.md
# Video memory DMA engine

This block runs the three block moves of a video controller: an external-memory-to-video-RAM transfer, a video RAM fill and a video RAM copy. Software programs a small set of byte registers: the length, the source, a mode field, the auto-increment step and a DMA-enable bit. A setup command strobe then supplies the destination address and starts the operation.

An external transfer raises a bus-hold request toward the CPU side and waits for a grant. It fetches 16-bit words and splits each one into two byte writes to video RAM. A fill waits for the next data-port write and repeats its low byte into video RAM. A copy reads a byte of video RAM and writes it back at the destination. Fill and copy never hold the CPU bus. A busy flag, meant for the status word, covers the whole operation.

Top module: `vram_dma`

## Requirements
- R1: The transfer length is 16 bits: register 19 holds the low byte and register 20 the high byte. Fill and copy count bytes. An external transfer counts 16-bit words.
- R2: A programmed length of 0 runs 65535 units, never zero units.
- R3: Register 23 bits 7:6 select the mode: bit 7 = 0 is an external transfer, 2'b10 is a fill and 2'b11 is a copy. The external source is the word address {reg23[5:0], reg22, reg21}. The copy source is the byte address {reg22, reg21}.
- R4: start_i is ignored unless register 1 bit 4 is set. A start that is ignored leaves busy_o low and writes nothing.
- R5: An external transfer raises bus_hold_o from the cycle after the start until its last byte write, and drops it in the next cycle. ext_rd_o is never asserted without ext_gnt_i.
- R6: Each external word is written with its high byte at the destination and its low byte at destination+1. The destination then advances by the auto-increment value (register 15), and the source word address advances by 1.
- R7: A fill waits, busy, for a data-port write. It then writes data_i[7:0] once per length unit, starting at the destination and advancing by the auto-increment value.
- R8: A copy reads the byte at the source and writes it at the destination. The source advances by 1 and the destination by the auto-increment value, once per length unit.
- R9: Fill and copy never assert bus_hold_o or ext_rd_o.
- R10: busy_o rises in the cycle after an accepted start and falls in the cycle after the last video RAM write. No write occurs while busy_o is low, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register index |
| reg_data_i | input | 8 | Register write data |
| start_i | input | 1 | Setup command strobe with a DMA request |
| dst_addr_i | input | 16 | Destination byte address carried by the command |
| data_wr_i | input | 1 | Data-port write strobe (fill trigger) |
| data_i | input | 16 | Data-port write value |
| bus_hold_o | output | 1 | Request to hold the CPU bus |
| ext_gnt_i | input | 1 | CPU bus granted |
| ext_rd_o | output | 1 | External word read request |
| ext_addr_o | output | 22 | External word address |
| ext_ack_i | input | 1 | External read data valid this cycle |
| ext_data_i | input | 16 | External read word |
| vram_we_o | output | 1 | Video RAM byte write enable |
| vram_waddr_o | output | 16 | Video RAM write address |
| vram_wdata_o | output | 8 | Video RAM write byte |
| vram_re_o | output | 1 | Video RAM byte read enable (data valid one cycle later) |
| vram_raddr_o | output | 16 | Video RAM read address |
| vram_rdata_i | input | 8 | Video RAM read byte |
| busy_o | output | 1 | DMA busy status bit |

## Verification
Register writes and the start strobe take effect at the next clock edge. The bench therefore samples busy_o and bus_hold_o at the falling edge one cycle after a start. The ignored-start case is checked at that same point. Video RAM writes go into a bench byte memory at each rising edge, and their number and placement are compared only after busy_o has fallen. The fill trigger, the delayed grant and the zero-length case are each held apart for several cycles before their results are compared.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 16;
  localparam int SRC_W  = 22;
  localparam int REG_IDX_W = 5;

  localparam logic [REG_IDX_W-1:0] IDX_MODE2  = 5'd1;
  localparam logic [REG_IDX_W-1:0] IDX_STEP   = 5'd15;
  localparam logic [REG_IDX_W-1:0] IDX_LEN_LO = 5'd19;
  localparam logic [REG_IDX_W-1:0] IDX_LEN_HI = 5'd20;
  localparam logic [REG_IDX_W-1:0] IDX_SRC_LO = 5'd21;
  localparam logic [REG_IDX_W-1:0] IDX_SRC_MD = 5'd22;
  localparam logic [REG_IDX_W-1:0] IDX_SRC_HI = 5'd23;
  localparam int EN_BIT = 4;

  typedef enum logic [1:0] {MV_EXT, MV_FILL, MV_COPY} move_e;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_EXT_RD, S_WR_HI, S_WR_LO,
    S_FILL_WAIT, S_FILL_WR, S_CP_RD, S_CP_WR
  } state_e;

  function automatic move_e decode_move(input logic [1:0] sel);
    if (!sel[1])     return MV_EXT;
    else if (sel[0]) return MV_COPY;
    else             return MV_FILL;
  endfunction
endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_wr_i,
  input  logic [REG_IDX_W-1:0]  reg_addr_i,
  input  logic [BYTE_W-1:0]     reg_data_i,
  output logic                  dma_en_o,
  output logic [BYTE_W-1:0]     step_o,
  output logic [LEN_W-1:0]      len_o,
  output logic [SRC_W-1:0]      src_o,
  output move_e                 move_o
);
  logic            en_q;
  logic [7:0]      step_q, len_lo_q, len_hi_q, src_lo_q, src_md_q, src_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      step_q   <= '0;
      len_lo_q <= '0;
      len_hi_q <= '0;
      src_lo_q <= '0;
      src_md_q <= '0;
      src_hi_q <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        IDX_MODE2:  en_q     <= reg_data_i[EN_BIT];
        IDX_STEP:   step_q   <= reg_data_i;
        IDX_LEN_LO: len_lo_q <= reg_data_i;
        IDX_LEN_HI: len_hi_q <= reg_data_i;
        IDX_SRC_LO: src_lo_q <= reg_data_i;
        IDX_SRC_MD: src_md_q <= reg_data_i;
        IDX_SRC_HI: src_hi_q <= reg_data_i;
        default: ;
      endcase
    end
  end

  assign dma_en_o = en_q;
  assign step_o   = step_q;
  assign len_o    = {len_hi_q, len_lo_q};
  assign src_o    = {src_hi_q[5:0], src_md_q, src_lo_q};
  assign move_o   = decode_move(src_hi_q[7:6]);
endmodule

// File: rtl/vdma_len_ctr.sv
module vdma_len_ctr
  import vdma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= (len_i == '0) ? {LEN_W{1'b1}} : len_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == LEN_W'(1));

  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q != '0); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0); // R2
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
  import vdma_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic              dma_en_i,
  input  move_e             move_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [BYTE_W-1:0] step_i,
  input  logic              data_wr_i,
  input  logic [15:0]       data_i,
  input  logic              cnt_last_i,
  output logic              load_o,
  output logic              dec_o,
  output logic              bus_hold_o,
  input  logic              ext_gnt_i,
  output logic              ext_rd_o,
  output logic [SRC_W-1:0]  ext_addr_o,
  input  logic              ext_ack_i,
  input  logic [15:0]       ext_data_i,
  output logic              vram_we_o,
  output logic [ADDR_W-1:0] vram_waddr_o,
  output logic [BYTE_W-1:0] vram_wdata_o,
  output logic              vram_re_o,
  output logic [ADDR_W-1:0] vram_raddr_o,
  input  logic [BYTE_W-1:0] vram_rdata_i,
  output logic              busy_o
);
  state_e             st_q, st_d;
  logic [SRC_W-1:0]   src_q;
  logic [ADDR_W-1:0]  dst_q;
  logic [BYTE_W-1:0]  step_q;
  logic [15:0]        word_q;
  logic               accept, advance;

  assign accept  = (st_q == S_IDLE) && start_i && dma_en_i;
  assign advance = (st_q == S_WR_LO) || (st_q == S_FILL_WR) || (st_q == S_CP_WR);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (accept) begin
        case (move_i)
          MV_EXT:  st_d = S_REQ;
          MV_FILL: st_d = S_FILL_WAIT;
          default: st_d = S_CP_RD;
        endcase
      end
      S_REQ:       if (ext_gnt_i) st_d = S_EXT_RD;
      S_EXT_RD:    if (ext_ack_i) st_d = S_WR_HI;
      S_WR_HI:     st_d = S_WR_LO;
      S_WR_LO:     st_d = cnt_last_i ? S_IDLE : S_REQ;
      S_FILL_WAIT: if (data_wr_i) st_d = S_FILL_WR;
      S_FILL_WR:   st_d = cnt_last_i ? S_IDLE : S_FILL_WR;
      S_CP_RD:     st_d = S_CP_WR;
      S_CP_WR:     st_d = cnt_last_i ? S_IDLE : S_CP_RD;
      default:     st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      step_q <= '0;
      word_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        src_q  <= src_i;
        dst_q  <= dst_i;
        step_q <= step_i;
      end
      if (st_q == S_EXT_RD && ext_ack_i)       word_q <= ext_data_i;
      if (st_q == S_FILL_WAIT && data_wr_i)    word_q <= data_i;
      if (advance) begin
        dst_q <= dst_q + ADDR_W'(step_q);
        if (st_q != S_FILL_WR) src_q <= src_q + 1'b1;
      end
    end
  end

  assign load_o     = accept;
  assign dec_o      = advance;
  assign busy_o     = (st_q != S_IDLE);
  assign bus_hold_o = (st_q == S_REQ) || (st_q == S_EXT_RD) ||
                      (st_q == S_WR_HI) || (st_q == S_WR_LO);
  assign ext_rd_o   = (st_q == S_EXT_RD);
  assign ext_addr_o = src_q;
  assign vram_re_o  = (st_q == S_CP_RD);
  assign vram_raddr_o = src_q[ADDR_W-1:0];
  assign vram_we_o  = (st_q == S_WR_HI) || advance;
  assign vram_waddr_o = (st_q == S_WR_LO) ? dst_q + 1'b1 : dst_q;

  always_comb begin
    case (st_q)
      S_WR_HI: vram_wdata_o = word_q[15:8];
      S_CP_WR: vram_wdata_o = vram_rdata_i;
      default: vram_wdata_o = word_q[7:0];
    endcase
  end

  AST_RD_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rd_o |-> ext_gnt_i); // R5
  AST_HOLD_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !bus_hold_o); // R5
  AST_WR_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vram_we_o |-> busy_o); // R10
  AST_RW_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vram_we_o && vram_re_o)); // R8
  AST_LOCAL_NO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vram_re_o || (st_q == S_FILL_WAIT)) |-> !bus_hold_o && !ext_rd_o); // R9
endmodule

// File: rtl/vram_dma.sv
module vram_dma
  import vdma_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [7:0]        reg_data_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic              data_wr_i,
  input  logic [15:0]       data_i,
  output logic              bus_hold_o,
  input  logic              ext_gnt_i,
  output logic              ext_rd_o,
  output logic [21:0]       ext_addr_o,
  input  logic              ext_ack_i,
  input  logic [15:0]       ext_data_i,
  output logic              vram_we_o,
  output logic [ADDR_W-1:0] vram_waddr_o,
  output logic [7:0]        vram_wdata_o,
  output logic              vram_re_o,
  output logic [ADDR_W-1:0] vram_raddr_o,
  input  logic [7:0]        vram_rdata_i,
  output logic              busy_o
);
  logic              dma_en;
  logic [BYTE_W-1:0] step;
  logic [LEN_W-1:0]  len;
  logic [SRC_W-1:0]  src;
  move_e             move;
  logic              load, dec, last;

  vdma_regs u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_data_i,
    .dma_en_o(dma_en), .step_o(step), .len_o(len), .src_o(src), .move_o(move)
  );

  vdma_len_ctr u_ctr (
    .clk_i, .rst_ni, .load_i(load), .len_i(len), .dec_i(dec), .last_o(last)
  );

  vdma_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .dst_i(dst_addr_i), .dma_en_i(dma_en),
    .move_i(move), .src_i(src), .step_i(step), .data_wr_i, .data_i,
    .cnt_last_i(last), .load_o(load), .dec_o(dec), .bus_hold_o,
    .ext_gnt_i, .ext_rd_o, .ext_addr_o, .ext_ack_i, .ext_data_i,
    .vram_we_o, .vram_waddr_o, .vram_wdata_o, .vram_re_o, .vram_raddr_o,
    .vram_rdata_i, .busy_o
  );

  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !dma_en && !busy_o) |=> !busy_o); // R4
endmodule

// File: tb/vram_dma_tb_top.sv
module vram_dma_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_N = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_data = '0;
  logic        start = 1'b0;
  logic [15:0] dst = '0;
  logic        data_wr = 1'b0;
  logic [15:0] data = '0;
  logic        gnt_en = 1'b1;
  logic        hold, ext_rd, ext_ack, ext_gnt, we, re, busy;
  logic [21:0] ext_addr;
  logic [15:0] ext_data, waddr, raddr;
  logic [7:0]  wdata;
  logic [7:0]  rdata = '0;
  logic [7:0]  mem [MEM_N];
  int          wr_cnt = 0, hold_cnt = 0, rd_cnt = 0;
  int          total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ext_gnt  = hold & gnt_en;
  assign ext_ack  = ext_rd & gnt_en;
  assign ext_data = {ext_addr[7:0] ^ 8'h3C, ext_addr[7:0] + 8'h11};

  vram_dma dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_data_i(reg_data), .start_i(start), .dst_addr_i(dst),
    .data_wr_i(data_wr), .data_i(data), .bus_hold_o(hold), .ext_gnt_i(ext_gnt),
    .ext_rd_o(ext_rd), .ext_addr_o(ext_addr), .ext_ack_i(ext_ack),
    .ext_data_i(ext_data), .vram_we_o(we), .vram_waddr_o(waddr),
    .vram_wdata_o(wdata), .vram_re_o(re), .vram_raddr_o(raddr),
    .vram_rdata_i(rdata), .busy_o(busy)
  );

  initial for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;

  always @(posedge clk) begin
    if (we) begin
      mem[waddr[11:0]] <= wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (hold)   hold_cnt <= hold_cnt + 1;
    if (ext_rd) rd_cnt   <= rd_cnt + 1;
    rdata <= mem[raddr[11:0]];
  end

  function automatic logic [7:0] hi_of(input logic [7:0] a); return a ^ 8'h3C; endfunction
  function automatic logic [7:0] lo_of(input logic [7:0] a); return a + 8'h11; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setreg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_data = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic set_len(input logic [15:0] n);
    setreg(5'd19, n[7:0]); setreg(5'd20, n[15:8]);
  endtask

  task automatic kick(input logic [15:0] d);
    @(negedge clk); start = 1'b1; dst = d;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 100000) begin @(negedge clk); n++; end
    if (busy) chk(1'b0, "R10 watchdog", n, 0);
  endtask

  task automatic t_reset();
    chk(!busy, "R10 reset busy", busy, 0);
    chk(!hold && !we && !ext_rd, "R5 reset outputs", {hold, we, ext_rd}, 0);
  endtask

  task automatic t_disabled();
    int w0 = wr_cnt;
    setreg(5'd1, 8'h00); setreg(5'd23, 8'h80); set_len(16'd3);
    kick(16'h0A00);
    chk(!busy, "R4 busy after ignored start", busy, 0);
    repeat (4) @(negedge clk);
    chk(wr_cnt == w0 && !busy, "R4 no writes when disabled", wr_cnt - w0, 0);
    setreg(5'd1, 8'h10);
  endtask

  task automatic t_ext();
    int w0 = wr_cnt, h0 = hold_cnt;
    bit ok = 1'b1;
    setreg(5'd15, 8'd2); set_len(16'd3);
    setreg(5'd21, 8'h40); setreg(5'd22, 8'h00); setreg(5'd23, 8'h00);
    kick(16'h0100);
    chk(busy && hold, "R5 hold in cycle after start", {busy, hold}, 3);
    wait_idle();
    chk(!hold, "R5 hold dropped at end", hold, 0);
    chk(wr_cnt - w0 == 6, "R1 ext word count", wr_cnt - w0, 6);
    chk(hold_cnt - h0 > 0, "R5 hold seen", hold_cnt - h0, 1);
    for (int k = 0; k < 3; k++) begin
      if (mem[12'h100 + 2*k] != hi_of(8'h40 + k[7:0])) ok = 1'b0;
      if (mem[12'h101 + 2*k] != lo_of(8'h40 + k[7:0])) ok = 1'b0;
    end
    chk(ok, "R6 byte order and step", mem[12'h102], hi_of(8'h41));
    chk(mem[12'h106] == 8'h00, "R3 ext stop at length", mem[12'h106], 0);
  endtask

  task automatic t_copy();
    int w0 = wr_cnt, h0 = hold_cnt, r0 = rd_cnt;
    bit ok = 1'b1;
    setreg(5'd15, 8'd1); set_len(16'd4);
    setreg(5'd21, 8'h00); setreg(5'd22, 8'h01); setreg(5'd23, 8'hC0);
    kick(16'h0300);
    wait_idle();
    chk(wr_cnt - w0 == 4, "R8 copy count", wr_cnt - w0, 4);
    ok = (mem[12'h300] == hi_of(8'h40)) && (mem[12'h301] == lo_of(8'h40)) &&
         (mem[12'h302] == hi_of(8'h41)) && (mem[12'h303] == lo_of(8'h41));
    chk(ok, "R8 copy data", mem[12'h303], lo_of(8'h41));
    chk(mem[12'h304] == 8'h00, "R8 copy bound", mem[12'h304], 0);
    chk(hold_cnt == h0 && rd_cnt == r0, "R9 copy no bus hold", hold_cnt - h0, 0);
  endtask

  task automatic t_fill(input logic [15:0] d, input logic [7:0] step, input int n);
    int w0 = wr_cnt, h0 = hold_cnt;
    bit ok = 1'b1;
    setreg(5'd15, step); set_len(16'(n)); setreg(5'd23, 8'h80);
    kick(d);
    repeat (3) @(negedge clk);
    chk(busy && wr_cnt == w0, "R7 fill waits for data write", wr_cnt - w0, 0);
    @(negedge clk); data_wr = 1'b1; data = 16'h12A5;
    @(negedge clk); data_wr = 1'b0;
    wait_idle();
    chk(wr_cnt - w0 == n, "R7 fill count", wr_cnt - w0, n);
    for (int k = 0; k < n; k++)
      if (mem[12'(d + k*step)] != 8'hA5) ok = 1'b0;
    chk(ok, "R7 fill data", mem[12'(d)], 8'hA5);
    chk(mem[12'(d + n*step)] == 8'h00, "R7 fill bound", mem[12'(d + n*step)], 0);
    if (step == 8'd2) chk(mem[12'(d + 1)] == 8'h00, "R7 fill skips gap", mem[12'(d + 1)], 0);
    chk(hold_cnt == h0, "R9 fill no bus hold", hold_cnt - h0, 0);
  endtask

  task automatic t_len_hi();
    int w0 = wr_cnt;
    setreg(5'd15, 8'd1); set_len(16'h0102); setreg(5'd23, 8'h80);
    kick(16'h0C00);
    @(negedge clk); data_wr = 1'b1; data = 16'h0077;
    @(negedge clk); data_wr = 1'b0;
    wait_idle();
    chk(wr_cnt - w0 == 258, "R1 high length byte", wr_cnt - w0, 258);
  endtask

  task automatic t_zero_len();
    int w0 = wr_cnt;
    setreg(5'd15, 8'd1); set_len(16'h0000); setreg(5'd23, 8'h80);
    kick(16'h0800);
    @(negedge clk); data_wr = 1'b1; data = 16'h0033;
    @(negedge clk); data_wr = 1'b0;
    wait_idle();
    chk(wr_cnt - w0 == 65535, "R2 zero length", wr_cnt - w0, 65535);
  endtask

  task automatic t_grant_wait();
    int r0 = rd_cnt, w0 = wr_cnt;
    gnt_en = 1'b0;
    setreg(5'd15, 8'd2); set_len(16'd1);
    setreg(5'd21, 8'h50); setreg(5'd22, 8'h00); setreg(5'd23, 8'h00);
    kick(16'h0600);
    repeat (6) @(negedge clk);
    chk(hold && busy && rd_cnt == r0 && wr_cnt == w0, "R5 no read before grant", rd_cnt - r0, 0);
    kick(16'h0700);
    gnt_en = 1'b1;
    wait_idle();
    chk(mem[12'h600] == hi_of(8'h50) && mem[12'h601] == lo_of(8'h50),
        "R6 after grant", mem[12'h601], lo_of(8'h50));
    chk(mem[12'h700] == 8'h00, "R10 start while busy ignored", mem[12'h700], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "R10 global watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_ext();
    t_copy();
    t_fill(16'h0200, 8'd1, 5);
    t_fill(16'h0400, 8'd2, 3);
    t_len_hi();
    t_grant_wait();
    t_zero_len();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule